// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves a small 8-bit controller between three operating conditions: running, idle (core asleep, peripherals awake) and power-down (oscillator stopped). Software arms a sleep request with a control write. The request takes hold only when the requesting instruction reports that it has retired. While asleep, the block withholds the core clock and, in power-down, the peripheral clock and the oscillator enable. It also forces the levels of the bus-control and port pins.

Idle ends on any pending enabled interrupt. Power-down ends only on an enabled, level-sensitive external interrupt pin held low. That pin starts the oscillator again, and clocks come back once a programmable settle count has run out and the pin has gone high again. A hardware reset ends either sleep.

A power-off flag is set by the power-on reset and survives warm resets, so software can tell a cold start from a warm one.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is applied, and until a sleep request is honoured, the core clock enable, peripheral clock enable and oscillator enable are all 1, and the bus override output is 0.
- R2: A write with `reqWr`=1 and `reqIdle`=1 (and `reqPd`=0) arms an idle request. On a later cycle with `instrDone`=1, the core clock enable goes to 0 while the peripheral clock and oscillator enables stay at 1. A write with both request bits 0 cancels an armed request.
- R3: A write with `reqPd`=1 arms a power-down request, and it takes priority over `reqIdle`. On a later `instrDone`, the core clock, peripheral clock and oscillator enables all go to 0.
- R4: In idle, `irqPending`=1 at a clock edge returns the block to run, with all clocks on after that edge.
- R5: In power-down, `irqPending` has no effect. An external pin low has no effect when its enable bit is 0 or its level bit is 0 (edge mode). All enables stay 0.
- R6: In power-down, an external pin held low with both its enable and level bits set raises the oscillator enable after the next edge and loads the settle counter with `settleCycles`. The counter counts down once per cycle. The clocks return at the first edge where the count is zero and every qualifying pin is high, which is `settleCycles`+1 edges after the wake edge if the pin is already released.
- R7: During any sleep, `busForce` is 1. During idle, `aleLvl` and `psenLvl` are 1. From power-down entry until the exit to run, both are 0.
- R8: During sleep, `p0Float` equals `extProgMem`. `p2Addr` is 1 in run, 1 in idle with `extProgMem`=1, and 0 otherwise.
- R9: `pwrOffFlag` becomes 1 on power-on reset (`porN`=0) and is not changed by `rstN`. A cycle with `flagWr`=1 loads `flagVal` into it.
- R10: If `instrDone` retires an armed request in the same cycle that `irqPending` or a qualifying external pin is active, the block stays in run and the request is dropped.
- R11: A hardware reset (`rstN`=0) in idle or power-down returns the block to run with all enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstN | input | 1 | Hardware (warm) reset, active low, asynchronous |
| reqWr | input | 1 | Control write strobe for sleep request |
| reqIdle | input | 1 | Idle request bit of the control write |
| reqPd | input | 1 | Power-down request bit of the control write |
| instrDone | input | 1 | Requesting instruction has retired |
| irqPending | input | 1 | Any enabled interrupt is pending |
| extIrqN | input | N_EXT | External interrupt pins, active low |
| extIrqEn | input | N_EXT | Per-pin interrupt enable |
| extIrqLevel | input | N_EXT | Per-pin mode: 1 level, 0 edge |
| settleCycles | input | CNT_W | Oscillator settle count |
| extProgMem | input | 1 | Program memory is external |
| flagWr | input | 1 | Software write of the power-off flag |
| flagVal | input | 1 | Value written to the power-off flag |
| cpuClkEn | output | 1 | Core clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| busForce | output | 1 | Pin levels below are forced (sleep) |
| aleLvl | output | 1 | Forced address-latch strobe level |
| psenLvl | output | 1 | Forced program-store strobe level |
| p0Float | output | 1 | Port 0 tri-stated |
| p2Addr | output | 1 | Port 2 carries address (1) or holds data (0) |
| pwrOffFlag | output | 1 | Cold-start flag |

## Verification
The colliding pair is sleep entry (an armed request retiring on `instrDone`) and wake detection (`irqPending` or a low level-mode pin). The bench arms an idle request and raises `instrDone` together with `irqPending`, then repeats the collision with a qualifying external pin held low. It judges that the core clock never drops. It then pulses `instrDone` alone and checks that the clocks still stay on, which shows that the request was dropped rather than kept armed.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_PD   = 2'd2,
    ST_OSC  = 2'd3
  } lpmState_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_IDLE = 2'd1,
    REQ_PD   = 2'd2
  } lpmReq_e;

  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic inIdle;
    logic inPd;
    logic inOsc;
  } lpmStrobe_t;
endpackage

// File: rtl/lpm_ctrl_fsm.sv
module lpm_ctrl_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqWr,
  input  logic       reqIdle,
  input  logic       reqPd,
  input  logic       instrDone,
  input  logic       irqPending,
  input  logic       wakeLine,
  input  logic       cntDone,
  output lpmStrobe_t strb
);
  lpmState_e st, stNext;
  lpmReq_e   pend, pendNext;
  logic      wakeAny;

  assign wakeAny = irqPending | wakeLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_RUN;
      pend <= REQ_NONE;
    end else begin
      st   <= stNext;
      pend <= pendNext;
    end
  end

  always_comb begin
    stNext   = st;
    pendNext = pend;
    unique case (st)
      ST_RUN: begin
        if (instrDone && pend != REQ_NONE) begin
          pendNext = REQ_NONE;
          if (!wakeAny) stNext = (pend == REQ_PD) ? ST_PD : ST_IDLE;
        end
        if (reqWr) begin
          if (reqPd)        pendNext = REQ_PD;
          else if (reqIdle) pendNext = REQ_IDLE;
          else              pendNext = REQ_NONE;
        end
      end
      ST_IDLE: if (irqPending) stNext = ST_RUN;
      ST_PD:   if (wakeLine)   stNext = ST_OSC;
      ST_OSC:  if (cntDone && !wakeLine) stNext = ST_RUN;
      default: stNext = ST_RUN;
    endcase
  end

  always_comb begin
    strb.cntLoad = (st == ST_PD) && wakeLine;
    strb.cntDec  = (st == ST_OSC);
    strb.inIdle  = (st == ST_IDLE);
    strb.inPd    = (st == ST_PD) || (st == ST_OSC);
    strb.inOsc   = (st == ST_OSC);
  end

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && irqPending) |=> st == ST_RUN);

  // R5
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PD && !wakeLine) |=> st == ST_PD);

  // R6
  settle_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_OSC && !cntDone) |=> st == ST_OSC);

  // R10
  collide_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && instrDone && wakeAny) |=> st == ST_RUN);
endmodule

// File: rtl/lpm_ctrl_dp.sv
module lpm_ctrl_dp
  import lpm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_EXT = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             sysRstN,
  input  lpmStrobe_t       strb,
  input  logic [CNT_W-1:0] settleCycles,
  input  logic [N_EXT-1:0] extIrqN,
  input  logic [N_EXT-1:0] extIrqEn,
  input  logic [N_EXT-1:0] extIrqLevel,
  input  logic             extProgMem,
  input  logic             flagWr,
  input  logic             flagVal,
  output logic             wakeLine,
  output logic             cntDone,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             oscEn,
  output logic             busForce,
  output logic             aleLvl,
  output logic             psenLvl,
  output logic             p0Float,
  output logic             p2Addr,
  output logic             pwrOffFlag
);
  logic [N_EXT-1:0] pinWake;
  logic [CNT_W-1:0] cnt;
  logic             flagQ;

  for (genvar i = 0; i < N_EXT; i++) begin : g_pin
    assign pinWake[i] = !extIrqN[i] && extIrqEn[i] && extIrqLevel[i];
  end
  assign wakeLine = |pinWake;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)                    cnt <= '0;
    else if (strb.cntLoad)           cnt <= settleCycles;
    else if (strb.cntDec && cnt != 0) cnt <= cnt - 1'b1;
  end
  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)       flagQ <= 1'b1;
    else if (flagWr) flagQ <= flagVal;
  end
  assign pwrOffFlag = flagQ;

  always_comb begin
    busForce  = strb.inIdle | strb.inPd;
    cpuClkEn  = !busForce;
    periClkEn = !strb.inPd;
    oscEn     = !strb.inPd || strb.inOsc;
    aleLvl    = !strb.inPd;
    psenLvl   = !strb.inPd;
    p0Float   = busForce && extProgMem;
    p2Addr    = !busForce || (strb.inIdle && extProgMem);
  end

  // R3
  no_clk_without_osc_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !oscEn |-> (!cpuClkEn && !periClkEn));

  // R9
  flag_stable_chk: assert property (@(posedge clk) disable iff (!porN)
    !flagWr |=> $stable(pwrOffFlag));

  // R6
  osc_on_settle_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (strb.inOsc && !cntDone) |-> (oscEn && !cpuClkEn));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_EXT = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  logic             reqWr,
  input  logic             reqIdle,
  input  logic             reqPd,
  input  logic             instrDone,
  input  logic             irqPending,
  input  logic [N_EXT-1:0] extIrqN,
  input  logic [N_EXT-1:0] extIrqEn,
  input  logic [N_EXT-1:0] extIrqLevel,
  input  logic [CNT_W-1:0] settleCycles,
  input  logic             extProgMem,
  input  logic             flagWr,
  input  logic             flagVal,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             oscEn,
  output logic             busForce,
  output logic             aleLvl,
  output logic             psenLvl,
  output logic             p0Float,
  output logic             p2Addr,
  output logic             pwrOffFlag
);
  logic       sysRstN;
  logic       wakeLine;
  logic       cntDone;
  lpmStrobe_t strb;

  assign sysRstN = rstN & porN;

  lpm_ctrl_fsm u_fsm (
    .clk        (clk),
    .rstN       (sysRstN),
    .reqWr      (reqWr),
    .reqIdle    (reqIdle),
    .reqPd      (reqPd),
    .instrDone  (instrDone),
    .irqPending (irqPending),
    .wakeLine   (wakeLine),
    .cntDone    (cntDone),
    .strb       (strb)
  );

  lpm_ctrl_dp #(.CNT_W(CNT_W), .N_EXT(N_EXT)) u_dp (
    .clk          (clk),
    .porN         (porN),
    .sysRstN      (sysRstN),
    .strb         (strb),
    .settleCycles (settleCycles),
    .extIrqN      (extIrqN),
    .extIrqEn     (extIrqEn),
    .extIrqLevel  (extIrqLevel),
    .extProgMem   (extProgMem),
    .flagWr       (flagWr),
    .flagVal      (flagVal),
    .wakeLine     (wakeLine),
    .cntDone      (cntDone),
    .cpuClkEn     (cpuClkEn),
    .periClkEn    (periClkEn),
    .oscEn        (oscEn),
    .busForce     (busForce),
    .aleLvl       (aleLvl),
    .psenLvl      (psenLvl),
    .p0Float      (p0Float),
    .p2Addr       (p2Addr),
    .pwrOffFlag   (pwrOffFlag)
  );
endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int CNT_W = 16;
  localparam int N_EXT = 2;

  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0;
  logic reqWr = 0, reqIdle = 0, reqPd = 0, instrDone = 0, irqPending = 0;
  logic [N_EXT-1:0] extIrqN = '1, extIrqEn = '0, extIrqLevel = '0;
  logic [CNT_W-1:0] settleCycles = '0;
  logic extProgMem = 0, flagWr = 0, flagVal = 0;
  logic cpuClkEn, periClkEn, oscEn, busForce, aleLvl, psenLvl, p0Float, p2Addr, pwrOffFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lpm_ctrl #(.CNT_W(CNT_W), .N_EXT(N_EXT)) uut (
    .clk(clk), .porN(porN), .rstN(rstN), .reqWr(reqWr), .reqIdle(reqIdle), .reqPd(reqPd),
    .instrDone(instrDone), .irqPending(irqPending), .extIrqN(extIrqN), .extIrqEn(extIrqEn),
    .extIrqLevel(extIrqLevel), .settleCycles(settleCycles), .extProgMem(extProgMem),
    .flagWr(flagWr), .flagVal(flagVal), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn),
    .oscEn(oscEn), .busForce(busForce), .aleLvl(aleLvl), .psenLvl(psenLvl),
    .p0Float(p0Float), .p2Addr(p2Addr), .pwrOffFlag(pwrOffFlag)
  );

  // vector: {isPd, extMem, ale, psen, p0Float, p2Addr}
  localparam logic [5:0] PIN_VEC [4] = '{
    6'b01_11_11, 6'b00_11_00, 6'b11_00_10, 6'b10_00_00
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hwReset();
    rstN = 1'b0; tick(); rstN = 1'b1; tick();
  endtask

  task automatic sleepReq(input logic pd, input logic idl);
    reqWr = 1; reqPd = pd; reqIdle = idl; tick();
    reqWr = 0; reqPd = 0; reqIdle = 0;
    instrDone = 1; tick(); instrDone = 0;
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 reset cpuClk", cpuClkEn, 1);
    chk("R1 reset osc", oscEn, 1);
    chk("R1 reset busForce", busForce, 0);
    chk("R9 por flag", pwrOffFlag, 1);
    porN = 1; rstN = 1; tick();

    // R7 R8 pin vectors
    for (int i = 0; i < 4; i++) begin
      extProgMem = PIN_VEC[i][4];
      sleepReq(PIN_VEC[i][5], !PIN_VEC[i][5]);
      chk("R7 busForce", busForce, 1);
      chk("R7 ale", aleLvl, PIN_VEC[i][3]);
      chk("R7 psen", psenLvl, PIN_VEC[i][2]);
      chk("R8 p0Float", p0Float, PIN_VEC[i][1]);
      chk("R8 p2Addr", p2Addr, PIN_VEC[i][0]);
      chk("R2 R3 cpuClk off", cpuClkEn, 0);
      chk("R2 R3 periClk", periClkEn, !PIN_VEC[i][5]);
      chk("R2 R3 osc", oscEn, !PIN_VEC[i][5]);
      hwReset();
      chk("R11 reset exits sleep", cpuClkEn, 1);
      chk("R11 osc back", oscEn, 1);
    end
    extProgMem = 0;
    chk("R8 p2Addr in run", p2Addr, 1);

    // R2: write without instrDone does nothing; cancel write drops request
    reqWr = 1; reqIdle = 1; tick(); reqWr = 0; reqIdle = 0; tick();
    chk("R2 no entry before retire", cpuClkEn, 1);
    reqWr = 1; tick(); reqWr = 0;
    instrDone = 1; tick(); instrDone = 0;
    chk("R2 cancelled request", cpuClkEn, 1);

    // R3 priority: both bits set -> power-down
    sleepReq(1, 1);
    chk("R3 pd priority osc", oscEn, 0);
    chk("R3 pd priority peri", periClkEn, 0);
    hwReset();

    // R4 idle wake
    sleepReq(0, 1);
    tick();
    chk("R4 idle holds", cpuClkEn, 0);
    irqPending = 1; tick(); irqPending = 0;
    chk("R4 idle wake", cpuClkEn, 1);

    // R5 power-down ignores non-qualifying sources
    sleepReq(1, 0);
    irqPending = 1; tick(); irqPending = 0;
    chk("R5 irqPending ignored", oscEn, 0);
    extIrqEn = 2'b10; extIrqLevel = 2'b00; extIrqN = 2'b01; tick();
    chk("R5 edge-mode pin ignored", oscEn, 0);
    extIrqEn = 2'b00; extIrqLevel = 2'b10; tick();
    chk("R5 disabled pin ignored", oscEn, 0);
    chk("R5 cpu stays off", cpuClkEn, 0);
    extIrqN = 2'b11;

    // R6 wake with settle 3, pin released at once
    settleCycles = 3; extIrqEn = 2'b10; extIrqLevel = 2'b10;
    extIrqN = 2'b01; tick(); extIrqN = 2'b11;
    chk("R6 osc restarts", oscEn, 1);
    chk("R6 cpu off at wake", cpuClkEn, 0);
    chk("R7 ale low while settling", aleLvl, 0);
    tick(); tick(); tick();
    chk("R6 still settling", cpuClkEn, 0);
    tick();
    chk("R6 clocks return", cpuClkEn, 1);
    chk("R6 peri return", periClkEn, 1);

    // R6 pin held low past count
    settleCycles = 1;
    sleepReq(1, 0);
    extIrqN = 2'b01; tick(); tick(); tick(); tick();
    chk("R6 held pin blocks exit", cpuClkEn, 0);
    extIrqN = 2'b11; tick();
    chk("R6 exit on release", cpuClkEn, 1);

    // R10 collision with irqPending
    reqWr = 1; reqIdle = 1; tick(); reqWr = 0; reqIdle = 0;
    instrDone = 1; irqPending = 1; tick(); instrDone = 0; irqPending = 0;
    chk("R10 stays run", cpuClkEn, 1);
    instrDone = 1; tick(); instrDone = 0;
    chk("R10 request dropped", cpuClkEn, 1);
    // R10 collision with qualifying pin
    reqWr = 1; reqPd = 1; tick(); reqWr = 0; reqPd = 0;
    instrDone = 1; extIrqN = 2'b01; tick(); instrDone = 0; extIrqN = 2'b11;
    chk("R10 pin collision run", oscEn, 1);
    instrDone = 1; tick(); instrDone = 0;
    chk("R10 pd request dropped", oscEn, 1);

    // R9 flag
    flagWr = 1; flagVal = 0; tick(); flagWr = 0;
    chk("R9 sw clear", pwrOffFlag, 0);
    hwReset();
    chk("R9 survives warm reset", pwrOffFlag, 0);
    flagWr = 1; flagVal = 1; tick(); flagWr = 0;
    chk("R9 sw set", pwrOffFlag, 1);
    flagWr = 1; flagVal = 0; tick(); flagWr = 0;
    porN = 0; tick(); porN = 1; tick();
    chk("R9 cold start sets", pwrOffFlag, 1);
    chk("R1 after por", cpuClkEn, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule